// File: doc/BRIEF.md
# PRBS-15 Link Bit Error Ratio Tester

This block produces and checks a pseudorandom test stream for the self-test of a serial link. It works on parallel words. The transmit half emits one word per clock toward a serializer. The receive half takes words from a deserializer. It builds its own copy of the sequence from the received bits, compares every received bit against that copy, and totals the wrong bits and the compared bits inside a measurement window that software or a test sequencer opens and closes. No line coding or checksum sits on the path, so every raw bit is tested.

The sequence obeys b[n] = b[n-14] XOR b[n-15], which is the x^15 + x^14 + 1 generator. Within a word, bit WORD_W-1 is the earliest bit of the stream and bit 0 is the latest. The checker has three states: seeding, hunting and locked. Once locked, its copy of the sequence runs on by itself, so a corrupted bit is counted once and does not disturb the next words. A one-cycle injection input flips a transmitted bit on request, which shows end to end that the checker detects and counts errors. Both counters saturate. A finished measurement is held until the next window starts. WORD_W must be at least 15.

Top module: `prbs_bert`

## Requirements
- R1: The transmit state resets to all ones. On every clock after reset, txData takes the next WORD_W bits of the sequence b[n] = b[n-14] XOR b[n-15], earliest bit in bit WORD_W-1, continuing without a gap from word to word.
- R2: When injErr is high at a clock edge, bit 0 of the word loaded at that edge is inverted. The sequence itself is not disturbed, so the following word is correct again.
- R3: After reset or after loss of lock, the first valid received word is not compared. Its low 15 bits become the checker's copy of the stream, so the checker follows whatever sequence phase arrives.
- R4: While hunting, each valid word is compared with the prediction and then reseeds the copy from its own low 15 bits. A mismatch restarts the run. `locked` rises after LOCK_WORDS (default 64) consecutive matching words following the seed.
- R5: While locked, the copy advances from its own prediction. A word with more than WORD_W/4 wrong bits is bad. LOSS_WORDS (default 8) consecutive bad words drop `locked`. A word with exactly WORD_W/4 wrong bits is not bad and ends the run.
- R6: Each valid word received while locked and with the window open adds its number of wrong bits to errCount and WORD_W to bitCount. Nothing is counted while unlocked.
- R7: A cycle with rxValid low changes neither the counters, nor the lock state, nor the checker's copy of the stream.
- R8: winStart clears both counters and opens the window. A word that arrives in the same cycle as winStart or winStop is not counted. After winStop, both counts hold their values.
- R9: errCount and bitCount stop at their all-ones values instead of wrapping.
- R10: During reset, txData, errCount and bitCount are zero and `locked` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| injErr | input | 1 | Invert bit 0 of the next transmitted word |
| txData | output | WORD_W | Pattern word toward the serializer |
| rxData | input | WORD_W | Word from the deserializer |
| rxValid | input | 1 | rxData holds a word in this cycle |
| winStart | input | 1 | Clear the counters and open the measurement window |
| winStop | input | 1 | Close the measurement window |
| locked | output | 1 | Checker is aligned to the received stream |
| errCount | output | ERR_W | Saturating count of wrong bits |
| bitCount | output | BIT_W | Saturating count of compared bits |

## Verification
The hardest conditions to reach from the ports are the thresholds of the locked state: a run of bad words that ends just short of loss, a word with exactly a quarter of its bits wrong that must reset that run, and an error counter driven to saturation without losing lock on the way. The stimulus builds each received word from an independent model of the stream and applies a chosen error mask to it. It interleaves seven full-inversion words with one quarter-wrong word to pile up errors safely. It also jumps the model to a new sequence phase after a deliberate loss, so that a relock can only happen if the checker really reseeds.

// File: rtl/bert_pkg.sv
package bert_pkg;

  localparam int PRBS_LEN = 15;

  typedef enum logic [1:0] {
    ST_SEED = 2'd0,
    ST_HUNT = 2'd1,
    ST_LOCK = 2'd2
  } chk_state_t;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic seedLoad;     // load replica from received word
    logic predAdvance;  // advance replica from its own prediction
    logic accumulate;   // add this word to the counters
    logic clearCounts;  // zero both counters
  } ctrl_strobes_t;

endpackage

// File: rtl/bert_prbs_word.sv
module bert_prbs_word #(
  parameter int WORD_W = 16
) (
  input  logic [14:0]       stateIn,
  output logic [WORD_W-1:0] wordOut
);

  logic [14:0] walk;

  // Unrolled x^15 + x^14 + 1 recurrence; earliest bit lands in the MSB
  always_comb begin
    walk    = stateIn;
    wordOut = '0;
    for (int i = 0; i < WORD_W; i++) begin
      wordOut[WORD_W-1-i] = walk[13] ^ walk[14];
      walk = {walk[13:0], walk[13] ^ walk[14]};
    end
  end

endmodule

// File: rtl/bert_datapath.sv
module bert_datapath
  import bert_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ERR_W  = 32,
  parameter int BIT_W  = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              injErr,
  output logic [WORD_W-1:0] txData,
  input  logic [WORD_W-1:0] rxData,
  input  ctrl_strobes_t     strb,
  output logic              mismatch,
  output logic              badWord,
  output logic [ERR_W-1:0]  errCount,
  output logic [BIT_W-1:0]  bitCount
);

  localparam int POP_W = $clog2(WORD_W + 1);
  localparam int BAD_LIMIT = WORD_W / 4;
  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};
  localparam logic [BIT_W-1:0] BIT_MAX = {BIT_W{1'b1}};
  localparam logic [14:0] SEED_ONES = {PRBS_LEN{1'b1}};

  // ---------------- transmit generator ----------------
  logic [14:0]       txState;
  logic [WORD_W-1:0] txNext;

  bert_prbs_word #(.WORD_W(WORD_W)) u_txGen (
    .stateIn(txState),
    .wordOut(txNext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      txState <= SEED_ONES;
      txData  <= '0;
    end else begin
      txState <= txNext[14:0];
      txData  <= txNext ^ {{(WORD_W-1){1'b0}}, injErr};
    end
  end

  // ---------------- receive replica and compare ----------------
  logic [14:0]       repState;
  logic [WORD_W-1:0] expWord;
  logic [WORD_W-1:0] diffWord;
  logic [POP_W-1:0]  errBits;

  bert_prbs_word #(.WORD_W(WORD_W)) u_repGen (
    .stateIn(repState),
    .wordOut(expWord)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      repState <= SEED_ONES;
    end else if (strb.seedLoad) begin
      repState <= rxData[14:0];
    end else if (strb.predAdvance) begin
      repState <= expWord[14:0];
    end
  end

  always_comb begin
    diffWord = rxData ^ expWord;
    errBits  = '0;
    for (int i = 0; i < WORD_W; i++) begin
      errBits = errBits + POP_W'(diffWord[i]);
    end
  end

  assign mismatch = |diffWord;
  assign badWord  = errBits > POP_W'(BAD_LIMIT);

  // ---------------- saturating counters ----------------
  logic [ERR_W:0] errSum;
  logic [BIT_W:0] bitSum;

  assign errSum = (ERR_W+1)'(errCount) + (ERR_W+1)'(errBits);
  assign bitSum = (BIT_W+1)'(bitCount) + (BIT_W+1)'(WORD_W);

  always_ff @(posedge clk) begin
    if (rst || strb.clearCounts) begin
      errCount <= '0;
      bitCount <= '0;
    end else if (strb.accumulate) begin
      errCount <= errSum[ERR_W] ? ERR_MAX : errSum[ERR_W-1:0];
      bitCount <= bitSum[BIT_W] ? BIT_MAX : bitSum[BIT_W-1:0];
    end
  end

  // ---------------- assertions ----------------
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!strb.accumulate && !strb.clearCounts) |=> ($stable(errCount) && $stable(bitCount)))
    else $error("counters moved without an accumulate strobe");

  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    strb.clearCounts |=> (errCount == '0 && bitCount == '0))
    else $error("counters not cleared at window start");

  p_err_sat_r9: assert property (@(posedge clk) disable iff (rst)
    (errCount == ERR_MAX && !strb.clearCounts) |=> errCount == ERR_MAX)
    else $error("error counter left saturation");

  p_bit_sat_r9: assert property (@(posedge clk) disable iff (rst)
    (bitCount == BIT_MAX && !strb.clearCounts) |=> bitCount == BIT_MAX)
    else $error("bit counter left saturation");

endmodule

// File: rtl/bert_control.sv
module bert_control
  import bert_pkg::*;
#(
  parameter int LOCK_WORDS = 64,
  parameter int LOSS_WORDS = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rxValid,
  input  logic          winStart,
  input  logic          winStop,
  input  logic          mismatch,
  input  logic          badWord,
  output ctrl_strobes_t strb,
  output logic          locked
);

  localparam int CLEAN_W = $clog2(LOCK_WORDS + 1);
  localparam int LOSS_W  = $clog2(LOSS_WORDS + 1);

  chk_state_t         state;
  logic [CLEAN_W-1:0] cleanRun;
  logic [LOSS_W-1:0]  badRun;
  logic               winOpen;

  assign locked = (state == ST_LOCK);

  always_comb begin
    strb = '0;
    strb.clearCounts = winStart;
    if (rxValid) begin
      unique case (state)
        ST_SEED, ST_HUNT: strb.seedLoad = 1'b1;
        ST_LOCK: begin
          strb.predAdvance = 1'b1;
          strb.accumulate  = winOpen && !winStart && !winStop;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      winOpen <= 1'b0;
    end else if (winStart) begin
      winOpen <= 1'b1;
    end else if (winStop) begin
      winOpen <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_SEED;
      cleanRun <= '0;
      badRun   <= '0;
    end else if (rxValid) begin
      unique case (state)
        ST_SEED: begin
          state    <= ST_HUNT;
          cleanRun <= '0;
        end
        ST_HUNT: begin
          if (mismatch) begin
            cleanRun <= '0;
          end else if (cleanRun == CLEAN_W'(LOCK_WORDS - 1)) begin
            state  <= ST_LOCK;
            badRun <= '0;
          end else begin
            cleanRun <= cleanRun + 1'b1;
          end
        end
        ST_LOCK: begin
          if (!badWord) begin
            badRun <= '0;
          end else if (badRun == LOSS_W'(LOSS_WORDS - 1)) begin
            state    <= ST_SEED;
            badRun   <= '0;
            cleanRun <= '0;
          end else begin
            badRun <= badRun + 1'b1;
          end
        end
        default: state <= ST_SEED;
      endcase
    end
  end

  p_lock_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> ($past(rxValid) && !$past(mismatch)))
    else $error("lock declared without a matching word");

  p_loss_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> ($past(rxValid) && $past(badWord)))
    else $error("lock dropped without a bad word");

endmodule

// File: rtl/prbs_bert.sv
module prbs_bert
  import bert_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int ERR_W      = 32,
  parameter int BIT_W      = 48,
  parameter int LOCK_WORDS = 64,
  parameter int LOSS_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              injErr,
  output logic [WORD_W-1:0] txData,
  input  logic [WORD_W-1:0] rxData,
  input  logic              rxValid,
  input  logic              winStart,
  input  logic              winStop,
  output logic              locked,
  output logic [ERR_W-1:0]  errCount,
  output logic [BIT_W-1:0]  bitCount
);

  ctrl_strobes_t strb;
  logic          mismatch;
  logic          badWord;

  bert_control #(
    .LOCK_WORDS(LOCK_WORDS),
    .LOSS_WORDS(LOSS_WORDS)
  ) u_control (
    .clk     (clk),
    .rst     (rst),
    .rxValid (rxValid),
    .winStart(winStart),
    .winStop (winStop),
    .mismatch(mismatch),
    .badWord (badWord),
    .strb    (strb),
    .locked  (locked)
  );

  bert_datapath #(
    .WORD_W(WORD_W),
    .ERR_W (ERR_W),
    .BIT_W (BIT_W)
  ) u_datapath (
    .clk     (clk),
    .rst     (rst),
    .injErr  (injErr),
    .txData  (txData),
    .rxData  (rxData),
    .strb    (strb),
    .mismatch(mismatch),
    .badWord (badWord),
    .errCount(errCount),
    .bitCount(bitCount)
  );

endmodule

// File: tb/prbs_bert_test.sv
`timescale 1ns/1ps
module prbs_bert_test;

  localparam int W  = 16;
  localparam int EW = 8;
  localparam int BW = 10;

  // {error mask, expected cumulative errCount}
  localparam logic [31:0] VEC [7] = '{
    {16'h0000, 16'd0},
    {16'h0001, 16'd1},
    {16'h8000, 16'd2},
    {16'h00FF, 16'd10},
    {16'h1111, 16'd14},
    {16'hFFFF, 16'd30},
    {16'h0000, 16'd30}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          injErr = 1'b0;
  logic [W-1:0]  txData;
  logic [W-1:0]  rxData = '0;
  logic          rxValid = 1'b0;
  logic          winStart = 1'b0;
  logic          winStop = 1'b0;
  logic          locked;
  logic [EW-1:0] errCount;
  logic [BW-1:0] bitCount;

  int compared = 0;
  int mismatched = 0;
  logic [14:0] txm;
  logic [14:0] rxm;

  always #2 clk = ~clk;

  prbs_bert #(.WORD_W(W), .ERR_W(EW), .BIT_W(BW)) uut (
    .clk(clk), .rst(rst), .injErr(injErr), .txData(txData),
    .rxData(rxData), .rxValid(rxValid), .winStart(winStart), .winStop(winStop),
    .locked(locked), .errCount(errCount), .bitCount(bitCount)
  );

  function automatic logic [W-1:0] pw(input logic [14:0] s);
    logic [14:0] t = s;
    logic [W-1:0] r = '0;
    for (int i = 0; i < W; i++) begin
      r[W-1-i] = t[13] ^ t[14];
      t = {t[13:0], t[13] ^ t[14]};
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One received word; the model stream advances with the true word
  task automatic sendWord(input logic [W-1:0] mask, input logic st, input logic sp);
    logic [W-1:0] w = pw(rxm);
    rxData = w ^ mask; rxValid = 1'b1; winStart = st; winStop = sp;
    rxm = w[14:0];
    @(posedge clk); @(negedge clk);
    rxValid = 1'b0; winStart = 1'b0; winStop = 1'b0; rxData = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      rxData = 16'hDEAD; rxValid = 1'b0;
      @(posedge clk); @(negedge clk);
    end
    rxData = '0;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10 txData in reset", 64'(txData), 64'h0);
    chk("R10 locked in reset", 64'(locked), 64'h0);
    chk("R10 errCount in reset", 64'(errCount), 64'h0);
    chk("R10 bitCount in reset", 64'(bitCount), 64'h0);
    rst = 1'b0;

    // R1 and R2: transmit sequence with one injected flip
    txm = 15'h7FFF;
    for (int i = 0; i < 12; i++) begin
      logic [W-1:0] w;
      injErr = (i == 5);
      @(posedge clk); @(negedge clk);
      injErr = 1'b0;
      w = pw(txm);
      txm = w[14:0];
      if (i == 5)      chk("R2 injected word bit0 flipped", 64'(txData), 64'(w ^ 16'h0001));
      else if (i == 6) chk("R2 word after injection clean", 64'(txData), 64'(w));
      else             chk("R1 tx sequence word", 64'(txData), 64'(w));
    end

    // R3/R4: seed, short clean run, mismatch restarts, then full run
    rxm = 15'h1234;
    sendWord('0, 1'b0, 1'b0);
    for (int i = 0; i < 10; i++) sendWord('0, 1'b0, 1'b0);
    sendWord(16'h8000, 1'b0, 1'b0);
    for (int i = 0; i < 63; i++) sendWord('0, 1'b0, 1'b0);
    chk("R4 not locked after 63 clean words", 64'(locked), 64'h0);
    sendWord('0, 1'b0, 1'b0);
    chk("R4 locked after 64 clean words", 64'(locked), 64'h1);
    chk("R6 nothing counted before window", 64'(bitCount), 64'h0);

    // R8: start word is not counted
    sendWord(16'h000F, 1'b1, 1'b0);
    chk("R8 start word not counted err", 64'(errCount), 64'h0);
    chk("R8 start word not counted bits", 64'(bitCount), 64'h0);

    // R7: invalid cycles with garbage
    idle(3);
    chk("R7 invalid cycles err", 64'(errCount), 64'h0);
    chk("R7 invalid cycles bits", 64'(bitCount), 64'h0);
    chk("R7 invalid cycles lock", 64'(locked), 64'h1);

    // R6: table of error masks
    for (int i = 0; i < 7; i++) begin
      sendWord(VEC[i][31:16], 1'b0, 1'b0);
      chk("R6 table errCount", 64'(errCount), 64'(VEC[i][15:0]));
      chk("R6 table bitCount", 64'(bitCount), 64'(16 * (i + 1)));
    end

    // R8: stop word not counted, counts held afterwards
    sendWord(16'h0003, 1'b0, 1'b1);
    sendWord(16'h00F0, 1'b0, 1'b0);
    chk("R8 held err after stop", 64'(errCount), 64'd30);
    chk("R8 held bits after stop", 64'(bitCount), 64'd112);

    // R5: bad-word run, quarter-wrong word resets it, then loss
    for (int i = 0; i < 7; i++) sendWord(16'hFFFF, 1'b0, 1'b0);
    sendWord(16'h000F, 1'b0, 1'b0);
    for (int i = 0; i < 7; i++) sendWord(16'hFFFF, 1'b0, 1'b0);
    chk("R5 still locked after 7 bad words", 64'(locked), 64'h1);
    sendWord(16'hFFFF, 1'b0, 1'b0);
    chk("R5 lock lost after 8 bad words", 64'(locked), 64'h0);

    // R3: jump to a new stream phase; checker must reseed
    rxm = 15'h0ABC;
    sendWord('0, 1'b0, 1'b0);
    for (int i = 0; i < 63; i++) sendWord('0, 1'b0, 1'b0);
    chk("R3 relock pending", 64'(locked), 64'h0);
    sendWord('0, 1'b0, 1'b0);
    chk("R3 relocked on new phase", 64'(locked), 64'h1);

    // R9: saturation
    sendWord('0, 1'b1, 1'b0);
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 7; i++) sendWord(16'hFFFF, 1'b0, 1'b0);
      sendWord(16'h000F, 1'b0, 1'b0);
      if (r == 1) chk("R9 err before saturation", 64'(errCount), 64'd232);
    end
    chk("R9 errCount saturated", 64'(errCount), 64'd255);
    chk("R9 bits before saturation", 64'(bitCount), 64'd384);
    for (int i = 0; i < 39; i++) sendWord('0, 1'b0, 1'b0);
    chk("R9 bits just below limit", 64'(bitCount), 64'd1008);
    sendWord('0, 1'b0, 1'b0);
    chk("R9 bitCount saturated", 64'(bitCount), 64'd1023);
    sendWord(16'h0001, 1'b0, 1'b0);
    chk("R9 bitCount stays saturated", 64'(bitCount), 64'd1023);
    chk("R9 errCount stays saturated", 64'(errCount), 64'd255);

    summary();
    $finish;
  end

endmodule